// File: doc/BRIEF.md
# Fault-Isolation Control Register File

This block is a bank of 64-bit control and status registers that software reaches over a simple word-addressed control bus. It holds a fault-isolation register that collects error bits, a mask for it, two action registers, a mode register, four address-window base and mask registers and a window-enable register. Hardware fault pulses also feed the fault register directly. Software can change the fault register and the mask without a read-modify-write, because each has separate alias addresses for overwrite, AND-clear and OR-set.

Each register keeps only the bits it defines and stores the other bits as zero. A protection check watches the window registers. A write to the base or mask of a window that is currently enabled raises a sticky violation flag, and the write still takes effect. A write to an index with no register is dropped and raises a separate sticky flag.

Reads are combinational: `bus_rdata` follows `bus_addr` and `bus_size` in the same cycle. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `fault_isolation_regfile`

## Requirements
- R1: An access is accepted only when `bus_size` equals 8 (a full 8-byte word). The register index is `bus_addr` shifted right by 3. A write of any other size changes nothing, and a read of any other size returns zero.
- R2: The fault register lives at index 0, where a write replaces its value. A write to index 1 ANDs the data into it, and a write to index 2 ORs the data into it. Reads of indices 0, 1 and 2 all return the fault register.
- R3: The mask lives at index 3, where a write replaces its value. A write to index 4 ANDs the data into it, and a write to index 5 ORs the data into it. Reads of indices 3, 4 and 5 all return the mask.
- R4: Indices 6 and 7 are plain read/write action registers. Any write to index 8 leaves that register at zero, whatever the data, and it always reads zero.
- R5: The mode register at index 12 keeps only bits 63:56. Its lower bits read as zero.
- R6: The window registers keep only these bits: indices 13 to 16 keep bits 63:24, index 17 keeps bits 63:22, and index 18 keeps bits 63:36.
- R7: The window-enable register at index 19 keeps only bits 63:60. Bit 63 enables window A (indices 13 and 14), bit 62 enables window B (indices 15 and 16), bit 61 enables the register window (index 17) and bit 60 enables the interrupt window (index 18).
- R8: A write to a window register whose own enable bit is set raises `win_violation`, which stays high until reset. The written value is still stored. A write to a window whose enable bit is clear leaves the flag unchanged.
- R9: Writes to indices 9, 10 and 11 are ignored, and these indices read zero.
- R10: A write to an index above 19 changes no register and raises `unmapped_hit`, which stays high until reset. A read of such an index returns zero.
- R11: Any set bit of `fault_in` is ORed into the fault register at the next edge. This happens even when a software write to the fault register lands in the same cycle, and the fault bits win over an overwrite or an AND-clear.
- R12: After reset every register reads zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address; the index is bits ADDR_W-1:3 |
| bus_size | input | 4 | Access size in bytes; only 8 is accepted |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| fault_in | input | DATA_W | Hardware fault pulses, ORed into the fault register |
| win_violation | output | 1 | Sticky flag: a write hit an enabled window |
| unmapped_hit | output | 1 | Sticky flag: a write hit an unmapped index |

## Verification
Assertions check the following on every cycle:
- both flags stay sticky;
- a fault pulse always shows up in the fault register;
- an AND-clear write without faults produces the old value ANDed with the data;
- writes of the wrong size, and writes to the ignored indices, leave the mask unchanged.

The bench scenarios cover the behaviour that needs a chosen sequence of writes: each kept-bit pattern, the alias read-back, the fault priority when a fault and a write land in the same cycle, and the violation flag staying low for a window that is disabled while another window is enabled.

// File: rtl/firf_pkg.sv
package firf_pkg;
   localparam int REG_W      = 64;
   localparam int IX_FIR     = 0;
   localparam int IX_FIR_AND = 1;
   localparam int IX_FIR_OR  = 2;
   localparam int IX_MSK     = 3;
   localparam int IX_MSK_AND = 4;
   localparam int IX_MSK_OR  = 5;
   localparam int IX_ACT0    = 6;
   localparam int IX_ACT1    = 7;
   localparam int IX_WOC     = 8;
   localparam int IX_ERR0    = 9;
   localparam int IX_ERR1    = 10;
   localparam int IX_STAT    = 11;
   localparam int IX_MODE    = 12;
   localparam int IX_WIN0    = 13;
   localparam int WIN_N      = 6;
   localparam int IX_WEN     = IX_WIN0 + WIN_N;
   localparam int IX_LAST    = IX_WEN;

   localparam logic [REG_W-1:0] MODE_KEEP = {8'hFF, 56'h0};
   localparam logic [REG_W-1:0] WEN_KEEP  = {4'hF, 60'h0};

   // kept bits of window register k (0..5)
   function automatic logic [REG_W-1:0] win_keep(input int k);
      logic [REG_W-1:0] m;
      int lo;
      lo = (k < 4) ? 24 : ((k == 4) ? 22 : 36);
      m = '0;
      for (int b = 0; b < REG_W; b++) m[b] = (b >= lo);
      return m;
   endfunction

   // position of the enable bit guarding window register k
   function automatic int win_en_pos(input int k);
      return (k < 4) ? (63 - k / 2) : (61 - (k - 4));
   endfunction
endpackage

// File: rtl/firf_alias_reg.sv
module firf_alias_reg #(
   parameter int W         = 64,
   parameter bit USE_FAULT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_direct,
   input  logic         wr_clr,
   input  logic         wr_set,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] fault,
   output logic [W-1:0] q
);
   logic [W-1:0] sw_next;
   logic [W-1:0] hw_bits;

   always_comb begin
      sw_next = q;
      if (wr_direct) sw_next = wdata;
      if (wr_clr)    sw_next = q & wdata;
      if (wr_set)    sw_next = q | wdata;
   end

   generate
      if (USE_FAULT) begin : g_fault
         assign hw_bits = fault;
      end else begin : g_nofault
         assign hw_bits = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= sw_next | hw_bits;
   end

   generate
      if (USE_FAULT) begin : g_fault_chk
         // R11
         fault_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fault != '0) |=> ((q & $past(fault)) == $past(fault)));
      end
   endgenerate
endmodule

// File: rtl/firf_keep_reg.sv
module firf_keep_reg #(
   parameter int           W    = 64,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end
endmodule

// File: rtl/firf_window_guard.sv
module firf_window_guard
   import firf_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [REG_W-1:0] en_q,
   output logic             violation
);
   logic [WIN_N-1:0] hit_en;

   generate
      for (genvar k = 0; k < WIN_N; k++) begin : g_hit
         assign hit_en[k] = (idx == IDX_W'(IX_WIN0 + k)) && en_q[win_en_pos(k)];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                 violation <= 1'b0;
      else if (wr && |hit_en)     violation <= 1'b1;
   end

   // R8
   violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);
endmodule

// File: rtl/fault_isolation_regfile.sv
module fault_isolation_regfile
   import firf_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] fault_in,
   output logic              win_violation,
   output logic              unmapped_hit
);
   localparam int IDX_W = ADDR_W - 3;

   generate
      if (DATA_W != REG_W) begin : g_bad_w
         $error("fault_isolation_regfile: DATA_W must be 64");
      end
      if ((1 << IDX_W) <= IX_LAST) begin : g_bad_a
         $error("fault_isolation_regfile: ADDR_W too small for the map");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              full, wr, mapped;
   logic [DATA_W-1:0] fir_q, msk_q, act0_q, act1_q, mode_q, wen_q;
   logic [DATA_W-1:0] win_q [WIN_N];

   assign idx    = bus_addr[ADDR_W-1:3];
   assign full   = (bus_size == 4'd8);
   assign wr     = bus_wr && full;
   assign mapped = (idx <= IDX_W'(IX_LAST));

   firf_alias_reg #(.W(DATA_W), .USE_FAULT(1'b1)) u_fir (
      .clk(clk), .rst_n(rst_n),
      .wr_direct(wr && idx == IDX_W'(IX_FIR)),
      .wr_clr(wr && idx == IDX_W'(IX_FIR_AND)),
      .wr_set(wr && idx == IDX_W'(IX_FIR_OR)),
      .wdata(bus_wdata), .fault(fault_in), .q(fir_q));

   firf_alias_reg #(.W(DATA_W), .USE_FAULT(1'b0)) u_msk (
      .clk(clk), .rst_n(rst_n),
      .wr_direct(wr && idx == IDX_W'(IX_MSK)),
      .wr_clr(wr && idx == IDX_W'(IX_MSK_AND)),
      .wr_set(wr && idx == IDX_W'(IX_MSK_OR)),
      .wdata(bus_wdata), .fault('0), .q(msk_q));

   firf_keep_reg #(.W(DATA_W), .KEEP('1)) u_act0 (
      .clk(clk), .rst_n(rst_n), .we(wr && idx == IDX_W'(IX_ACT0)),
      .wdata(bus_wdata), .q(act0_q));

   firf_keep_reg #(.W(DATA_W), .KEEP('1)) u_act1 (
      .clk(clk), .rst_n(rst_n), .we(wr && idx == IDX_W'(IX_ACT1)),
      .wdata(bus_wdata), .q(act1_q));

   firf_keep_reg #(.W(DATA_W), .KEEP(MODE_KEEP)) u_mode (
      .clk(clk), .rst_n(rst_n), .we(wr && idx == IDX_W'(IX_MODE)),
      .wdata(bus_wdata), .q(mode_q));

   firf_keep_reg #(.W(DATA_W), .KEEP(WEN_KEEP)) u_wen (
      .clk(clk), .rst_n(rst_n), .we(wr && idx == IDX_W'(IX_WEN)),
      .wdata(bus_wdata), .q(wen_q));

   generate
      for (genvar k = 0; k < WIN_N; k++) begin : g_win
         firf_keep_reg #(.W(DATA_W), .KEEP(win_keep(k))) u_win (
            .clk(clk), .rst_n(rst_n), .we(wr && idx == IDX_W'(IX_WIN0 + k)),
            .wdata(bus_wdata), .q(win_q[k]));
      end
   endgenerate

   firf_window_guard #(.IDX_W(IDX_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .en_q(wen_q),
      .violation(win_violation));

   always_ff @(posedge clk) begin
      if (!rst_n)               unmapped_hit <= 1'b0;
      else if (wr && !mapped)   unmapped_hit <= 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      if (full) begin
         if (idx <= IDX_W'(IX_FIR_OR))                                 bus_rdata = fir_q;
         else if (idx <= IDX_W'(IX_MSK_OR))                            bus_rdata = msk_q;
         else if (idx == IDX_W'(IX_ACT0))                              bus_rdata = act0_q;
         else if (idx == IDX_W'(IX_ACT1))                              bus_rdata = act1_q;
         else if (idx == IDX_W'(IX_MODE))                              bus_rdata = mode_q;
         else if (idx == IDX_W'(IX_WEN))                               bus_rdata = wen_q;
         else if (idx >= IDX_W'(IX_WIN0) && idx < IDX_W'(IX_WEN))      bus_rdata = win_q[idx - IDX_W'(IX_WIN0)];
      end
   end

   // R10
   unmapped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_hit |=> unmapped_hit);

   // R2
   fir_clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == IDX_W'(IX_FIR_AND) && fault_in == '0) |=> fir_q == $past(fir_q & bus_wdata));

   // R1
   partial_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !full) |=> $stable(msk_q));

   // R9
   ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx >= IDX_W'(IX_ERR0) && idx <= IDX_W'(IX_STAT)) |=> ($stable(msk_q) && $stable(mode_q)));
endmodule

// File: tb/fault_isolation_regfile_bench.sv
`timescale 1ns/1ps
module fault_isolation_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_size = 4'd8;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [63:0] fault_in = '0;
   logic        win_violation, unmapped_hit;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fault_isolation_regfile u_fault_isolation_regfile (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fault_in(fault_in), .win_violation(win_violation), .unmapped_hit(unmapped_hit));

   typedef struct packed {
      logic [4:0]  widx;
      logic [63:0] wdata;
      logic [4:0]  ridx;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{5'd0,  64'hF0F0_0000_0000_00FF, 5'd0,  64'hF0F0_0000_0000_00FF}, // R2 direct
      '{5'd1,  64'hFFFF_0000_0000_000F, 5'd1,  64'hF0F0_0000_0000_000F}, // R2 and
      '{5'd2,  64'h0000_0000_0000_1100, 5'd0,  64'hF0F0_0000_0000_110F}, // R2 or
      '{5'd3,  64'h1234_5678_9ABC_DEF0, 5'd3,  64'h1234_5678_9ABC_DEF0}, // R3 direct
      '{5'd4,  64'hFFFF_0000_FFFF_0000, 5'd3,  64'h1234_0000_9ABC_0000}, // R3 and
      '{5'd5,  64'h0000_0000_0000_000F, 5'd5,  64'h1234_0000_9ABC_000F}, // R3 or
      '{5'd6,  64'hDEAD_BEEF_0123_4567, 5'd6,  64'hDEAD_BEEF_0123_4567}, // R4 act0
      '{5'd7,  64'h0F0F_0F0F_0F0F_0F0F, 5'd7,  64'h0F0F_0F0F_0F0F_0F0F}, // R4 act1
      '{5'd8,  64'hFFFF_FFFF_FFFF_FFFF, 5'd8,  64'h0},                   // R4 write-zero
      '{5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 5'd12, 64'hFF00_0000_0000_0000}, // R5
      '{5'd13, 64'hFFFF_FFFF_FFFF_FFFF, 5'd13, 64'hFFFF_FFFF_FF00_0000}, // R6
      '{5'd14, 64'h0123_4567_89AB_CDEF, 5'd14, 64'h0123_4567_8900_0000}, // R6
      '{5'd15, 64'hFFFF_FFFF_FFFF_FFFF, 5'd15, 64'hFFFF_FFFF_FF00_0000}, // R6
      '{5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 5'd16, 64'hFFFF_FFFF_FF00_0000}, // R6
      '{5'd17, 64'hFFFF_FFFF_FFFF_FFFF, 5'd17, 64'hFFFF_FFFF_FFC0_0000}, // R6
      '{5'd18, 64'hFFFF_FFFF_FFFF_FFFF, 5'd18, 64'hFFFF_FFF0_0000_0000}, // R6
      '{5'd9,  64'hFFFF_FFFF_FFFF_FFFF, 5'd9,  64'h0},                   // R9
      '{5'd11, 64'hFFFF_FFFF_FFFF_FFFF, 5'd11, 64'h0},                   // R9
      '{5'd6,  64'h1111_2222_3333_4444, 5'd7,  64'h0F0F_0F0F_0F0F_0F0F}, // R4 act1 untouched
      '{5'd19, 64'hFFFF_FFFF_FFFF_FFFF, 5'd19, 64'hF000_0000_0000_0000}  // R7
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int idx, input logic [63:0] d, input logic [63:0] flt = '0,
                         input logic [3:0] sz = 4'd8);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'(idx << 3); bus_wdata = d; bus_size = sz; fault_in = flt;
      @(negedge clk);
      bus_wr = 1'b0; fault_in = '0; bus_size = 4'd8;
   endtask

   task automatic rd_chk(input string tag, input int idx, input logic [63:0] exp,
                         input logic [3:0] sz = 4'd8);
      bus_addr = 8'(idx << 3); bus_size = sz;
      #1;
      chk(tag, bus_rdata, exp);
      bus_size = 4'd8;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R12 reset state
      rd_chk("R12 fir", 0, 64'h0);
      rd_chk("R12 mask", 3, 64'h0);
      rd_chk("R12 wen", 19, 64'h0);
      chk("R12 violation", {63'h0, win_violation}, 64'h0);
      chk("R12 unmapped", {63'h0, unmapped_hit}, 64'h0);

      for (int v = 0; v < NV; v++) begin
         wr_reg(int'(VECS[v].widx), VECS[v].wdata);
         rd_chk($sformatf("vector %0d", v), int'(VECS[v].ridx), VECS[v].exp);
      end
      // R8 windows written while disabled: no violation
      chk("R8 no violation while disabled", {63'h0, win_violation}, 64'h0);

      // R11 fault priority over AND-clear, overwrite and OR-set
      wr_reg(1, 64'h0, 64'h80);
      rd_chk("R11 clear+fault", 0, 64'h80);
      wr_reg(2, 64'h1, 64'h4);
      rd_chk("R11 set+fault", 0, 64'h85);
      @(negedge clk); fault_in = 64'h100; @(negedge clk); fault_in = '0;
      rd_chk("R11 fault alone", 0, 64'h185);
      wr_reg(0, 64'h0, 64'h2);
      rd_chk("R11 direct+fault", 0, 64'h2);

      // R1 partial size
      wr_reg(0, 64'hFFFF, '0, 4'd4);
      rd_chk("R1 partial write dropped", 0, 64'h2);
      rd_chk("R1 partial read zero", 6, 64'h0, 4'd4);
      rd_chk("R1 full read", 6, 64'h1111_2222_3333_4444);

      // R10 unmapped
      wr_reg(25, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R10 unmapped read", 25, 64'h0);
      chk("R10 unmapped flag", {63'h0, unmapped_hit}, 64'h1);
      rd_chk("R10 fir untouched", 0, 64'h2);
      chk("R10 no violation", {63'h0, win_violation}, 64'h0);

      // R8 enabled-window write
      wr_reg(17, 64'h0);
      chk("R8 violation raised", {63'h0, win_violation}, 64'h1);
      rd_chk("R8 write still lands", 17, 64'h0);

      // R8/R7 per-window enable matching
      do_reset();
      chk("R12 flags after reset", {62'h0, win_violation, unmapped_hit}, 64'h0);
      wr_reg(19, 64'h4000_0000_0000_0000);
      wr_reg(13, 64'hAB00_0000_0000_0000);
      chk("R7 window A disabled: no violation", {63'h0, win_violation}, 64'h0);
      rd_chk("R6 window A stored", 13, 64'hAB00_0000_0000_0000);
      wr_reg(16, 64'h1234_5678_9000_0000);
      chk("R8 window B enabled: violation", {63'h0, win_violation}, 64'h1);
      rd_chk("R8 window B stored", 16, 64'h1234_5678_9000_0000);
      wr_reg(12, 64'h0);
      chk("R8 violation sticky", {63'h0, win_violation}, 64'h1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule